// File: doc/BRIEF.md
# Page Access Permission Checker

This block judges one memory access against the leaf entry that a table walk has already fetched. It receives the entry, the access kind (read, write or execute), the privilege state of the requester and a two-bit read/write enable that has been reduced from the authority mask register. From these it works out which kinds of access the page grants. It then decides whether the requested kind may proceed. When the access is refused, it reports a fault cause.

On an accepted access, the block returns the entry with its reference and change bits brought up to date. If the updated entry differs from the original, it raises a write-back request on a valid/ready handshake. On a refused access, it produces an interrupt: an instruction storage interrupt for execute accesses, or a data storage interrupt for loads and stores. For a data interrupt it supplies a status word and captures the faulting effective address.

The block is pulsed with `start` and answers one clock later with a single-cycle `done`. Its result outputs hold their values until the next accepted request.

Top module: `pgperm_check`

## Requirements
- R1: A `start` sampled high at a rising edge while `wb_valid` is low is accepted. `done` is then high for exactly the following cycle. The result outputs (`allowed`, `perm`, `cause`, `new_pte`, `status`, `irq_instr`, `fault_addr`) keep their values until the next accepted request.
- R2: Entry field layout and the I/O execute rule:
  - bits 2:0 are the grant field {exec, write, read};
  - bit 3 marks a supervisor-only page;
  - bits 5:4 are the page attribute, where code 2'b11 means non-idempotent I/O;
  - bit 7 is the change bit and bit 8 is the reference bit.
  An execute access (`acc_type` 2) to an I/O page is refused with `cause` bit 0 (guarded) set.
- R3: An access in user mode (`user_mode`=1) to a supervisor-only page receives an empty permission set, so it is always refused with `cause` bit 1 (protection).
- R4: In user mode, or for a supervisor-only page, the permission set equals the grant field alone. `mask_rw` has no effect in that case.
- R5: In supervisor mode on a page that is not supervisor-only, the permission set is the grant field ANDed with {1, `mask_rw[1]`, `mask_rw[0]`}. The mask never restricts execute.
- R6: Access codes are 0 read, 1 write, 2 execute, and code 3 is treated as a read. If the permission that the code requires is missing, the access is refused with `cause` bit 1. Every refused access reports `perm`=0, `new_pte` equal to the input entry, and no write-back.
- R7: On an allowed access, `new_pte` is the input entry with bit 8 set, and a write also sets bit 7. For any access other than a write, `perm` bit 1 (write) is cleared. An allowed access reports `cause`=0.
- R8: A write-back is requested only when `new_pte` differs from the input entry. `wb_valid` then rises together with `done`, carrying `wb_addr`=`pte_addr` and `wb_data`=`new_pte`, and holds them stable until `wb_ready` is sampled high. A `start` that arrives while `wb_valid` is high is ignored.
- R9: A refused access pulses `irq_valid` with `done`.
  - An execute access sets `irq_instr`=1, `status`=`cause` and `fault_addr`=0.
  - A read or write access sets `irq_instr`=0, `status`=`cause` with bit 2 (store) added for writes, and `fault_addr`=`eff_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 read |
| user_mode | input | 1 | 1 = user (problem) state |
| pte | input | PTE_W (64) | Leaf entry from the walk |
| mask_rw | input | 2 | Authority mask enables {write, read} |
| eff_addr | input | EA_W (64) | Effective address of the access |
| pte_addr | input | PA_W (56) | Address the leaf entry was read from |
| wb_ready | input | 1 | Memory accepts the write-back |
| done | output | 1 | One-cycle result strobe |
| allowed | output | 1 | Access permitted |
| perm | output | 3 | Returned permissions {exec, write, read} |
| cause | output | 3 | Fault cause: bit 0 guarded, bit 1 protection |
| new_pte | output | PTE_W (64) | Entry with reference/change bits updated |
| wb_valid | output | 1 | Write-back request |
| wb_addr | output | PA_W (56) | Write-back address |
| wb_data | output | PTE_W (64) | Write-back data |
| irq_valid | output | 1 | Storage interrupt strobe |
| irq_instr | output | 1 | 1 instruction storage, 0 data storage |
| status | output | 3 | Interrupt status: cause plus bit 2 store |
| fault_addr | output | EA_W (64) | Captured effective address for data faults |

## Verification
All decision outputs, the updated entry, `irq_valid` and the rise of `wb_valid` appear after the first rising edge that follows an accepted `start`. The bench therefore drives each request on a falling edge and compares every result on the next falling edge. One falling edge later, it confirms that `done` has dropped. `wb_valid` falls one edge after `wb_ready` is sampled, and the bench checks it at the falling edge after the one where it raised `wb_ready`. An ignored `start` is checked on the falling edge after the edge where it was sampled, by observing that `done` stays low and the held results are unchanged.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;

    // access codes
    localparam logic [1:0] ACC_RD = 2'd0;
    localparam logic [1:0] ACC_WR = 2'd1;
    localparam logic [1:0] ACC_EX = 2'd2;

    // permission vector bit positions {exec, write, read}
    localparam int PERM_W  = 3;
    localparam int P_READ  = 0;
    localparam int P_WRITE = 1;
    localparam int P_EXEC  = 2;

    // leaf entry fields
    localparam int GRANT_LSB = 0;
    localparam int SUPV_BIT  = 3;
    localparam int ATTR_LSB  = 4;
    localparam int ATTR_W    = 2;
    localparam logic [ATTR_W-1:0] ATTR_NIO = 2'b11;
    localparam int CHG_BIT   = 7;
    localparam int REF_BIT   = 8;

    // cause / status bits
    localparam int CAUSE_W     = 3;
    localparam int CAUSE_GUARD = 0;
    localparam int CAUSE_PROT  = 1;
    localparam int CAUSE_STORE = 2;

endpackage

// File: rtl/pgperm_eval.sv
module pgperm_eval
    import pgperm_pkg::*;
(
    input  logic [1:0]         acc,
    input  logic               user_mode,
    input  logic [PERM_W-1:0]  grant,
    input  logic               supv_only,
    input  logic [ATTR_W-1:0]  attr,
    input  logic [1:0]         mask_rw,
    output logic [PERM_W-1:0]  perm_set,
    output logic               ok,
    output logic [CAUSE_W-1:0] fcause
);
    logic              io_exec;
    logic [PERM_W-1:0] need;
    logic [PERM_W-1:0] mask_perm;

    always_comb begin
        io_exec   = (attr == ATTR_NIO) && (acc == ACC_EX);
        mask_perm = {1'b1, mask_rw};

        unique case (acc)
            ACC_WR:  need = PERM_W'(1) << P_WRITE;
            ACC_EX:  need = PERM_W'(1) << P_EXEC;
            default: need = PERM_W'(1) << P_READ;
        endcase

        if (supv_only && user_mode)
            perm_set = '0;
        else if (user_mode || supv_only)
            perm_set = grant;
        else
            perm_set = grant & mask_perm;

        fcause = '0;
        if (io_exec) begin
            perm_set            = '0;
            fcause[CAUSE_GUARD] = 1'b1;
        end else if ((need & ~perm_set) != '0) begin
            fcause[CAUSE_PROT] = 1'b1;
        end
        ok = (fcause == '0);
    end
endmodule

// File: rtl/pgperm_rc.sv
module pgperm_rc
    import pgperm_pkg::*;
#(
    parameter int PTE_W = 64
) (
    input  logic [PTE_W-1:0] pte_in,
    input  logic             is_write,
    output logic [PTE_W-1:0] pte_out,
    output logic             differs
);
    always_comb begin
        pte_out          = pte_in;
        pte_out[REF_BIT] = 1'b1;
        if (is_write)
            pte_out[CHG_BIT] = 1'b1;
        differs = (pte_out != pte_in);
    end
endmodule

// File: rtl/pgperm_fault.sv
module pgperm_fault
    import pgperm_pkg::*;
#(
    parameter int EA_W = 64
) (
    input  logic               refuse,
    input  logic [1:0]         acc,
    input  logic [CAUSE_W-1:0] fcause,
    input  logic [EA_W-1:0]    ea,
    output logic               irq,
    output logic               instr,
    output logic [CAUSE_W-1:0] stat,
    output logic [EA_W-1:0]    addr
);
    always_comb begin
        irq   = refuse;
        instr = (acc == ACC_EX);
        stat  = fcause;
        addr  = '0;
        if (!instr) begin
            addr = ea;
            if (acc == ACC_WR)
                stat[CAUSE_STORE] = 1'b1;
        end
    end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
    import pgperm_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int EA_W  = 64,
    parameter int PA_W  = 56
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [1:0]         acc_type,
    input  logic               user_mode,
    input  logic [PTE_W-1:0]   pte,
    input  logic [1:0]         mask_rw,
    input  logic [EA_W-1:0]    eff_addr,
    input  logic [PA_W-1:0]    pte_addr,
    input  logic               wb_ready,
    output logic               done,
    output logic               allowed,
    output logic [PERM_W-1:0]  perm,
    output logic [CAUSE_W-1:0] cause,
    output logic [PTE_W-1:0]   new_pte,
    output logic               wb_valid,
    output logic [PA_W-1:0]    wb_addr,
    output logic [PTE_W-1:0]   wb_data,
    output logic               irq_valid,
    output logic               irq_instr,
    output logic [CAUSE_W-1:0] status,
    output logic [EA_W-1:0]    fault_addr
);
    typedef struct packed {
        logic               done;
        logic               allowed;
        logic [PERM_W-1:0]  perm;
        logic [CAUSE_W-1:0] cause;
        logic [PTE_W-1:0]   new_pte;
        logic               wb_valid;
        logic [PA_W-1:0]    wb_addr;
        logic [PTE_W-1:0]   wb_data;
        logic               irq_valid;
        logic               irq_instr;
        logic [CAUSE_W-1:0] status;
        logic [EA_W-1:0]    fault_addr;
    } state_t;

    state_t st_d, st_q;

    logic [PERM_W-1:0]  ev_perm;
    logic               ev_ok;
    logic [CAUSE_W-1:0] ev_cause;
    logic [PTE_W-1:0]   rc_pte;
    logic               rc_diff;
    logic               ff_irq, ff_instr;
    logic [CAUSE_W-1:0] ff_stat;
    logic [EA_W-1:0]    ff_addr;
    logic               accept;
    logic               is_write;

    assign is_write = (acc_type == ACC_WR);
    assign accept   = start && !st_q.wb_valid;

    pgperm_eval u_eval (
        .acc       (acc_type),
        .user_mode (user_mode),
        .grant     (pte[GRANT_LSB +: PERM_W]),
        .supv_only (pte[SUPV_BIT]),
        .attr      (pte[ATTR_LSB +: ATTR_W]),
        .mask_rw   (mask_rw),
        .perm_set  (ev_perm),
        .ok        (ev_ok),
        .fcause    (ev_cause)
    );

    pgperm_rc #(.PTE_W(PTE_W)) u_rc (
        .pte_in   (pte),
        .is_write (is_write),
        .pte_out  (rc_pte),
        .differs  (rc_diff)
    );

    pgperm_fault #(.EA_W(EA_W)) u_fault (
        .refuse (!ev_ok),
        .acc    (acc_type),
        .fcause (ev_cause),
        .ea     (eff_addr),
        .irq    (ff_irq),
        .instr  (ff_instr),
        .stat   (ff_stat),
        .addr   (ff_addr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.irq_valid = 1'b0;
        if (st_q.wb_valid && wb_ready)
            st_d.wb_valid = 1'b0;

        if (accept) begin
            st_d.done       = 1'b1;
            st_d.allowed    = ev_ok;
            st_d.cause      = ev_cause;
            st_d.irq_valid  = ff_irq;
            st_d.irq_instr  = ff_instr;
            st_d.status     = ff_stat;
            st_d.fault_addr = ff_addr;
            if (ev_ok) begin
                st_d.perm     = is_write ? ev_perm
                                         : (ev_perm & ~(PERM_W'(1) << P_WRITE));
                st_d.new_pte  = rc_pte;
                st_d.wb_valid = rc_diff;
                st_d.wb_addr  = pte_addr;
                st_d.wb_data  = rc_pte;
            end else begin
                st_d.perm     = '0;
                st_d.new_pte  = pte;
                st_d.wb_valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign done       = st_q.done;
    assign allowed    = st_q.allowed;
    assign perm       = st_q.perm;
    assign cause      = st_q.cause;
    assign new_pte    = st_q.new_pte;
    assign wb_valid   = st_q.wb_valid;
    assign wb_addr    = st_q.wb_addr;
    assign wb_data    = st_q.wb_data;
    assign irq_valid  = st_q.irq_valid;
    assign irq_instr  = st_q.irq_instr;
    assign status     = st_q.status;
    assign fault_addr = st_q.fault_addr;
endmodule

// File: rtl/pgperm_check_sva.sv
module pgperm_check_sva
    import pgperm_pkg::*;
#(
    parameter int PTE_W = 64,
    parameter int EA_W  = 64,
    parameter int PA_W  = 56
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic [1:0]         acc_type,
    input logic               user_mode,
    input logic [PTE_W-1:0]   pte,
    input logic [1:0]         mask_rw,
    input logic [EA_W-1:0]    eff_addr,
    input logic [PA_W-1:0]    pte_addr,
    input logic               wb_ready,
    input logic               done,
    input logic               allowed,
    input logic [PERM_W-1:0]  perm,
    input logic [CAUSE_W-1:0] cause,
    input logic [PTE_W-1:0]   new_pte,
    input logic               wb_valid,
    input logic [PA_W-1:0]    wb_addr,
    input logic [PTE_W-1:0]   wb_data,
    input logic               irq_valid,
    input logic               irq_instr,
    input logic [CAUSE_W-1:0] status,
    input logic [EA_W-1:0]    fault_addr
);
    assert_done_after_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start && !wb_valid |=> done);

    assert_no_spurious_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && !wb_valid) |=> !done);

    assert_supv_user_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start && !wb_valid && user_mode && pte[SUPV_BIT] |=> done && !allowed);

    assert_refuse_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !allowed |-> perm == '0 && !wb_valid && cause != '0);

    assert_ref_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done && allowed |-> new_pte[REF_BIT] && cause == '0);

    assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_addr));

    assert_irq_pairs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> done && !allowed);

    assert_instr_no_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid && irq_instr |-> fault_addr == '0 && !status[CAUSE_STORE]);
endmodule

bind pgperm_check pgperm_check_sva #(.PTE_W(PTE_W), .EA_W(EA_W), .PA_W(PA_W)) u_sva (.*);

// File: tb/pgperm_check_test.sv
module pgperm_check_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  acc_type = '0;
    logic        user_mode = 1'b0;
    logic [63:0] pte = '0;
    logic [1:0]  mask_rw = '0;
    logic [63:0] eff_addr = '0;
    logic [55:0] pte_addr = '0;
    logic        wb_ready = 1'b0;
    logic        done, allowed, wb_valid, irq_valid, irq_instr;
    logic [2:0]  perm, cause, status;
    logic [63:0] new_pte, wb_data, fault_addr;
    logic [55:0] wb_addr;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgperm_check uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent model of the requirements
    task automatic model(input logic [1:0] a, input logic u, input logic [63:0] p,
                         input logic [1:0] m, input logic [63:0] ea,
                         output logic ok, output logic [2:0] pm, output logic [2:0] cs,
                         output logic [63:0] np, output logic wb,
                         output logic instr, output logic [2:0] st,
                         output logic [63:0] fa);
        logic [2:0] g, need;
        g = p[2:0];
        need = (a == 2'd1) ? 3'b010 : (a == 2'd2) ? 3'b100 : 3'b001;
        cs = 3'b000;
        if (p[5:4] == 2'b11 && a == 2'd2) begin
            pm = 3'b000; cs = 3'b001;                       // R2
        end else begin
            if (u && p[3])        pm = 3'b000;              // R3
            else if (u || p[3])   pm = g;                   // R4
            else                  pm = g & {1'b1, m[1], m[0]}; // R5
            if ((need & pm) == 3'b000) cs = 3'b010;         // R6
        end
        ok = (cs == 3'b000);
        np = p; wb = 1'b0;
        if (ok) begin                                       // R7
            np[8] = 1'b1;
            if (a == 2'd1) np[7] = 1'b1;
            else pm[1] = 1'b0;
            wb = (np != p);                                 // R8
        end else pm = 3'b000;
        instr = (a == 2'd2);                                // R9
        st = cs;
        fa = '0;
        if (!instr) begin
            fa = ea;
            if (a == 2'd1) st[2] = 1'b1;
        end
    endtask

    task automatic access(input logic [1:0] a, input logic u, input logic [63:0] p,
                          input logic [1:0] m, input logic [63:0] ea,
                          input logic [55:0] pa, input bit release_wb);
        logic ok, wb, instr;
        logic [2:0] pm, cs, st;
        logic [63:0] np, fa;
        model(a, u, p, m, ea, ok, pm, cs, np, wb, instr, st, fa);
        @(negedge clk);
        acc_type = a; user_mode = u; pte = p; mask_rw = m; eff_addr = ea;
        pte_addr = pa; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b1, "R1 done", 64'(done), 64'd1);
        chk(allowed === ok, "R6 allowed", 64'(allowed), 64'(ok));
        chk(perm === pm, "R4/R5 perm", 64'(perm), 64'(pm));
        chk(cause === cs, "R2/R6 cause", 64'(cause), 64'(cs));
        chk(new_pte === np, "R7 new_pte", new_pte, np);
        chk(wb_valid === wb, "R8 wb_valid", 64'(wb_valid), 64'(wb));
        if (wb) begin
            chk(wb_data === np, "R8 wb_data", wb_data, np);
            chk(wb_addr === pa, "R8 wb_addr", 64'(wb_addr), 64'(pa));
        end
        chk(irq_valid === !ok, "R9 irq_valid", 64'(irq_valid), 64'(!ok));
        if (!ok) begin
            chk(irq_instr === instr, "R9 irq_instr", 64'(irq_instr), 64'(instr));
            chk(status === st, "R9 status", 64'(status), 64'(st));
            chk(fault_addr === fa, "R9 fault_addr", fault_addr, fa);
        end
        @(negedge clk);
        chk(done === 1'b0, "R1 done one cycle", 64'(done), 64'd0);
        chk(allowed === ok && perm === pm, "R1 results held",
            {61'd0, perm}, {61'd0, pm});
        if (wb && release_wb) begin
            wb_ready = 1'b1;
            @(negedge clk);
            wb_ready = 1'b0;
            chk(wb_valid === 1'b0, "R8 wb released", 64'(wb_valid), 64'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && wb_valid === 1'b0 && irq_valid === 1'b0,
            "R1 reset state", {61'd0, done, wb_valid, irq_valid}, 64'd0);

        // R2: I/O page refuses execute even with full grant
        access(2'd2, 1'b0, 64'h0000_0000_0000_0037, 2'b11, 64'h1234, 56'h80, 1);
        // R2: I/O page still readable
        access(2'd0, 1'b0, 64'h0000_0000_0000_0031, 2'b00, 64'h1238, 56'h88, 1);
        // R3: supervisor-only page from user mode
        access(2'd0, 1'b1, 64'h0000_0000_0000_010F, 2'b11, 64'hABC0, 56'h90, 1);
        // R4: user mode ignores mask
        access(2'd1, 1'b1, 64'h0000_0000_0000_0182, 2'b00, 64'hABC8, 56'h98, 1);
        // R5: supervisor, mask blocks write
        access(2'd1, 1'b0, 64'h0000_0000_0000_0187, 2'b01, 64'hBEEF, 56'hA0, 1);
        // R5: mask never blocks execute
        access(2'd2, 1'b0, 64'h0000_0000_0000_0004, 2'b00, 64'hC000, 56'hA8, 1);
        // R7: read of referenced page, write removed, no write-back
        access(2'd0, 1'b0, 64'h0000_0000_0000_0103, 2'b11, 64'hC008, 56'hB0, 1);
        // R8: write with R and C already set -> no write-back
        access(2'd1, 1'b1, 64'h0000_0000_0000_0182, 2'b00, 64'hC010, 56'hB8, 1);
        // R6: access code 3 acts as read
        access(2'd3, 1'b1, 64'h0000_0000_0000_0001, 2'b00, 64'hC018, 56'hC0, 1);

        // R8: start while write-back pending is ignored
        access(2'd1, 1'b0, 64'h0000_0000_0000_0003, 2'b11, 64'hD000, 56'hC8, 0);
        @(negedge clk);
        pte = 64'h0000_0000_0000_010F; user_mode = 1'b1; acc_type = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0, "R8 start ignored done", 64'(done), 64'd0);
        chk(allowed === 1'b1 && new_pte === 64'h0000_0000_0000_0183,
            "R8 start ignored results", new_pte, 64'h183);
        chk(wb_valid === 1'b1, "R8 wb still pending", 64'(wb_valid), 64'd1);
        wb_ready = 1'b1;
        @(negedge clk);
        wb_ready = 1'b0;
        chk(wb_valid === 1'b0, "R8 wb released", 64'(wb_valid), 64'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [63:0] p;
            p = {$urandom, $urandom};
            access(2'($urandom % 4), 1'($urandom), p, 2'($urandom),
                   {$urandom, $urandom}, 56'({$urandom, $urandom}), 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule